// File: doc/BRIEF.md
# Dual-Code Line Transmit Serializer

This block turns a stream of parallel code groups into a single serial line stream. Each group (five bits by default) is presented once per word period and sent out on a bit clock that runs five times faster, most significant bit first. The bit clock is the only clock in the block. A word-period strobe, derived inside the block from that clock, tells the upstream source when its group is captured.

A port-select input chooses the line code. With the twisted-pair port chosen, the stream is MLT-3 coded onto a signed two-bit level. With the fiber port chosen, the stream is NRZI coded onto a single level bit. The port choice is latched only at a group boundary. A transmit-off input forces a true quiet line with no transitions and returns the coder to a known starting state. A loopback tap presents the coded stream of the active port to the receive side without disturbing the line outputs.

Top module: `tx_dual_serializer`

## Requirements
- R1: A group is captured on the rising edge of `clk_bit` at which `grp_take` is high. `grp_take` is high for exactly one cycle in every GROUP_W cycles, and it is high in the first cycle after reset. `tx_group` is ignored in all other cycles.
- R2: The bits of a group go out in order from bit GROUP_W-1 down to bit 0, one bit per bit clock. The line level for the first bit appears after the capturing edge, and each later bit appears one edge after the previous one.
- R3: With the twisted-pair port active (`port_tp`=1 latched), each 1 bit steps `tp_level` through the cycle 0, +1, 0, -1, 0, ... and each 0 bit holds it. Levels are two's complement: 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. 2'b10 never appears.
- R4: With the fiber port active (`port_tp`=0 latched), each 1 bit inverts `fib_level` and each 0 bit holds it.
- R5: `port_tp` is sampled only at the capturing edge of a group. A change in the middle of a group takes effect at the next group.
- R6: The output of the inactive port is held quiet (`tp_level`=0, `fib_level`=0). After a port change, the newly active coder starts from its reset state: NRZI low, or MLT-3 at 0 with its next step toward +1.
- R7: After any rising edge with `tx_off`=1, `tp_level` is 0 and `fib_level` is 0. The serializer keeps advancing, so `grp_take` keeps its period.
- R8: The first bit coded after `tx_off` is released starts from the reset state of the coder, as in R6.
- R9: After each edge, `lb_level` equals the level driven on the active port by that same edge when `loop_en` was 1 at that edge. For the twisted-pair port this is the MLT-3 level; for the fiber port it is 2'b01 for a high level and 2'b00 for a low one. When `loop_en` was 0 at that edge, `lb_level` is 2'b00. `loop_en` has no effect on `tp_level` or `fib_level`.
- R10: While `rst_n` is low, `grp_take` is 1 and `tp_level`, `fib_level` and `lb_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, five times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_group | input | GROUP_W | Parallel code group to send |
| port_tp | input | 1 | 1 selects MLT-3 (twisted pair), 0 selects NRZI (fiber) |
| tx_off | input | 1 | Forces a quiet line and resets the coder |
| loop_en | input | 1 | Enables the loopback tap |
| grp_take | output | 1 | High in the cycle whose rising edge captures `tx_group` |
| tp_level | output | 2 | Signed MLT-3 line level |
| fib_level | output | 1 | NRZI line level |
| lb_level | output | 2 | Signed loopback copy of the active coded level |

## Verification
Every output comes from a register, so each result is due exactly one rising edge after the inputs that cause it. The level for the first bit of a group appears after the same edge that captures the group and at which `grp_take` was high. Each following bit appears one edge later, and the loopback level appears after the edge at which `loop_en` was sampled. The bench drives inputs and samples outputs on the falling edge. Right after each rising edge it pushes one expected item per bit into a queue. The monitor pops that item at the next falling edge, so each comparison lands in the cycle the result is due. In the middle of a group the driver inverts `tx_group` and changes `port_tp`; the expected items take no notice of those changes, which tests that mid-group input is ignored.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

   // Signed two-bit line level, two's complement
   typedef logic signed [1:0] line_lvl_t;

   localparam line_lvl_t LVL_ZERO = 2'sb00;
   localparam line_lvl_t LVL_POS  = 2'sb01;
   localparam line_lvl_t LVL_NEG  = 2'sb11;

   // Position in the four-step MLT-3 cycle
   typedef enum logic [1:0] {
      MLT_ZA = 2'd0,
      MLT_HI = 2'd1,
      MLT_ZB = 2'd2,
      MLT_LO = 2'd3
   } mlt_step_e;

   function automatic line_lvl_t mlt_level(input mlt_step_e s);
      case (s)
         MLT_HI:  return LVL_POS;
         MLT_LO:  return LVL_NEG;
         default: return LVL_ZERO;
      endcase
   endfunction

   function automatic mlt_step_e mlt_advance(input mlt_step_e s);
      case (s)
         MLT_ZA:  return MLT_HI;
         MLT_HI:  return MLT_ZB;
         MLT_ZB:  return MLT_LO;
         default: return MLT_ZA;
      endcase
   endfunction

endpackage

// File: rtl/tx_ser_phase.sv
module tx_ser_phase #(
   parameter int GROUP_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic load
);
   localparam int CW = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(GROUP_W - 1);

   logic [CW-1:0] cnt_q;

   assign load = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LAST;
      end else if (load) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1
   load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);

endmodule

// File: rtl/tx_ser_shift.sv
module tx_ser_shift #(
   parameter int GROUP_W   = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [GROUP_W-1:0] grp_in,
   output logic               bit_nx
);
   localparam int RW = GROUP_W - 1;

   logic [RW-1:0] rest_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rest_q <= '0;
            end else if (load) begin
               rest_q <= grp_in[GROUP_W-2:0];
            end else begin
               rest_q <= rest_q << 1;
            end
         end
         assign bit_nx = load ? grp_in[GROUP_W-1] : rest_q[RW-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rest_q <= '0;
            end else if (load) begin
               rest_q <= grp_in[GROUP_W-1:1];
            end else begin
               rest_q <= rest_q >> 1;
            end
         end
         assign bit_nx = load ? grp_in[0] : rest_q[0];
      end
   endgenerate

endmodule

// File: rtl/tx_ser_coder.sv
module tx_ser_coder
   import tx_ser_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  logic      port_tp,
   input  logic      tx_off,
   input  logic      loop_en,
   input  logic      bit_nx,
   output line_lvl_t tp_lvl,
   output logic      fib_lvl,
   output line_lvl_t lb_lvl
);
   logic      port_q;
   logic      port_nx;
   mlt_step_e st_q, st_d;
   logic      nrz_q, nrz_d;
   line_lvl_t lb_d;

   // Port choice is only taken at a group boundary
   assign port_nx = load ? port_tp : port_q;

   always_comb begin
      st_d  = st_q;
      nrz_d = nrz_q;
      if (tx_off) begin
         st_d  = MLT_ZA;
         nrz_d = 1'b0;
      end else if (port_nx) begin
         nrz_d = 1'b0;
         if (bit_nx) st_d = mlt_advance(st_q);
      end else begin
         st_d = MLT_ZA;
         if (bit_nx) nrz_d = ~nrz_q;
      end
   end

   always_comb begin
      if (!loop_en)     lb_d = LVL_ZERO;
      else if (port_nx) lb_d = mlt_level(st_d);
      else              lb_d = nrz_d ? LVL_POS : LVL_ZERO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= 1'b0;
         st_q   <= MLT_ZA;
         nrz_q  <= 1'b0;
         lb_lvl <= LVL_ZERO;
      end else begin
         port_q <= port_nx;
         st_q   <= st_d;
         nrz_q  <= nrz_d;
         lb_lvl <= lb_d;
      end
   end

   assign tp_lvl  = mlt_level(st_q);
   assign fib_lvl = nrz_q;

   // R7
   quiet_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_off |=> (tp_lvl == LVL_ZERO && !fib_lvl));

   // R4
   nrzi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_off && !port_nx && bit_nx) |=> (fib_lvl != $past(fib_lvl)));

   // R3
   mlt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_off && port_nx && !bit_nx) |=> $stable(tp_lvl));

   // R3
   mlt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tp_lvl != 2'sb10);

   // R5
   port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(port_q));

   // R6
   fib_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_nx |=> !fib_lvl);

   // R6
   tp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_nx |=> (tp_lvl == LVL_ZERO));

   // R9
   loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |=> (lb_lvl == LVL_ZERO));

endmodule

// File: rtl/tx_dual_serializer.sv
module tx_dual_serializer
   import tx_ser_pkg::*;
#(
   parameter int GROUP_W   = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk_bit,
   input  logic               rst_n,
   input  logic [GROUP_W-1:0] tx_group,
   input  logic               port_tp,
   input  logic               tx_off,
   input  logic               loop_en,
   output logic               grp_take,
   output logic [1:0]         tp_level,
   output logic               fib_level,
   output logic [1:0]         lb_level
);
   generate
      if (GROUP_W < 2 || GROUP_W > 16) begin : g_bad_width
         $error("tx_dual_serializer: GROUP_W must lie in 2..16");
      end
   endgenerate

   logic      load;
   logic      bit_nx;
   line_lvl_t tp_s;
   line_lvl_t lb_s;

   tx_ser_phase #(.GROUP_W(GROUP_W)) u_phase (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .load  (load)
   );

   tx_ser_shift #(.GROUP_W(GROUP_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk    (clk_bit),
      .rst_n  (rst_n),
      .load   (load),
      .grp_in (tx_group),
      .bit_nx (bit_nx)
   );

   tx_ser_coder u_coder (
      .clk     (clk_bit),
      .rst_n   (rst_n),
      .load    (load),
      .port_tp (port_tp),
      .tx_off  (tx_off),
      .loop_en (loop_en),
      .bit_nx  (bit_nx),
      .tp_lvl  (tp_s),
      .fib_lvl (fib_level),
      .lb_lvl  (lb_s)
   );

   assign grp_take = load;
   assign tp_level = tp_s;
   assign lb_level = lb_s;

   // R9
   loop_mirror_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (loop_en && port_tp && load) |=> (lb_level == tp_level));

endmodule

// File: tb/tx_dual_serializer_tb_top.sv
`timescale 1ns/1ps
module tx_dual_serializer_tb_top;

   typedef struct {
      logic [1:0] tp;
      logic       fib;
      logic [1:0] lb;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] tx_group = '0;
   logic       port_tp = 1'b0;
   logic       tx_off = 1'b0;
   logic       loop_en = 1'b0;
   logic       grp_take;
   logic [1:0] tp_level;
   logic       fib_level;
   logic [1:0] lb_level;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   // reference coder state
   int   m_st = 0;
   bit   m_nrz = 1'b0;
   bit   m_port = 1'b0;

   always #2.5 clk = ~clk;

   tx_dual_serializer #(.GROUP_W(5), .MSB_FIRST(1'b1)) dut_i (
      .clk_bit   (clk),
      .rst_n     (rst_n),
      .tx_group  (tx_group),
      .port_tp   (port_tp),
      .tx_off    (tx_off),
      .loop_en   (loop_en),
      .grp_take  (grp_take),
      .tp_level  (tp_level),
      .fib_level (fib_level),
      .lb_level  (lb_level)
   );

   function automatic logic [1:0] mlt_of(input int s);
      if (s == 1) return 2'b01;
      if (s == 3) return 2'b11;
      return 2'b00;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Driver: one group, five bit cycles; entered and left on a falling edge
   task automatic run_group(input logic [4:0] g, input bit prt, input bit prt_late,
                            input bit off, input bit lp, input string tag);
      for (int k = 0; k < 5; k++) begin
         exp_t e;
         bit   b;
         tx_group = (k == 0) ? g : ~g;
         port_tp  = (k == 0) ? prt : prt_late;
         tx_off   = off;
         loop_en  = lp;
         chk(grp_take == (k == 0), "R1", "grp_take", grp_take, (k == 0));
         @(posedge clk);
         #1;
         if (k == 0) m_port = prt;
         b = g[4-k];
         if (off) begin
            m_st = 0;
            m_nrz = 1'b0;
         end else if (m_port) begin
            m_nrz = 1'b0;
            if (b) m_st = (m_st + 1) % 4;
         end else begin
            m_st = 0;
            if (b) m_nrz = ~m_nrz;
         end
         e.tp  = m_port ? mlt_of(m_st) : 2'b00;
         e.fib = m_nrz;
         e.lb  = !lp ? 2'b00 : (m_port ? mlt_of(m_st) : {1'b0, m_nrz});
         e.tag = tag;
         sb_q.push_back(e);
         @(negedge clk);
      end
   endtask

   // Monitor: compares each due result one half cycle after it is produced
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk(tp_level == e.tp, e.tag, "tp_level", tp_level, e.tp);
         chk(fib_level == e.fib, e.tag, "fib_level", fib_level, e.fib);
         chk(lb_level == e.lb, e.tag, "lb_level", lb_level, e.lb);
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(grp_take == 1'b1, "R10", "grp_take", grp_take, 1);
      chk(tp_level == 2'b00, "R10", "tp_level", tp_level, 0);
      chk(fib_level == 1'b0, "R10", "fib_level", fib_level, 0);
      chk(lb_level == 2'b00, "R10", "lb_level", lb_level, 0);
      rst_n = 1'b1;

      // Fiber NRZI, bit order and pattern variety
      run_group(5'b10110, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
      run_group(5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      run_group(5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      run_group(5'b10001, 1'b0, 1'b0, 1'b0, 1'b1, "R9");

      // Twisted-pair MLT-3 across the full level cycle
      run_group(5'b10000, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      run_group(5'b11111, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
      run_group(5'b11111, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
      run_group(5'b01010, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
      run_group(5'b00100, 1'b1, 1'b1, 1'b0, 1'b1, "R3");

      // Port switches start from reset state
      run_group(5'b01000, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      run_group(5'b10000, 1'b1, 1'b1, 1'b0, 1'b1, "R6");

      // Mid-group port changes wait for the boundary
      run_group(5'b11011, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      run_group(5'b11011, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
      run_group(5'b01101, 1'b1, 1'b0, 1'b0, 1'b1, "R5");

      // Transmit-off and release
      run_group(5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
      run_group(5'b10000, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
      run_group(5'b11111, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      run_group(5'b10101, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
      run_group(5'b10000, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule